// File: doc/BRIEF.md
# Minimal 8-bit Register-Machine Core

This block is a small 8-bit processor core. It holds four 8-bit general registers, and the last of them (index 3) is the program counter. Each instruction is one byte, taken from a single 256-byte memory that holds both code and data. The core decodes each byte in one of two layouts. In the register layout, a four-bit operation selects between two register operands. In the immediate layout, a two-bit operation carries a four-bit constant, and that constant is split over two separate bit fields of the byte.

Every instruction takes two clock cycles. In the fetch cycle the core reads the byte at the program counter and advances the counter. In the execute cycle it performs the operation. The available operations are:
- nibble loads;
- add and NAND;
- memory load and store;
- peripheral read and write;
- an unsigned compare that can skip the next instruction;
- a register exchange.

The program counter is an ordinary register, so any operation that writes index 3 acts as a jump. The surrounding system supplies the memory, which is read combinationally, and the peripherals.

Top module: `mini_risc_core`

## Requirements
- R1: While reset is asserted and for the first fetch after its release, all registers including the program counter are 0: the memory address is 0, and the memory write enable and both peripheral strobes are low.
- R2: Each instruction takes a fetch cycle followed by an execute cycle. The fetch reads memory at the program counter and increments it, so reading register 3 during execute yields the address of the following instruction.
- R3: In the immediate layout, bits [7:6] are the operation, bits [3:2] are the target register, and the constant is {bits[5:4], bits[1:0]}. Operation 00 loads the constant into the low nibble and clears the high nibble.
- R4: Immediate operation 01 replaces the high nibble of the target with the constant and keeps its low nibble.
- R5: Register layout: bits [7:4] are the operation, [3:2] are rA and [1:0] are rB. Operation 1000 sets rA to rA + rB, modulo 256.
- R6: Operation 1001 sets rA to the bitwise NOT of (rA AND rB).
- R7: Operation 1010 loads rA from the peripheral at address rB with a one-cycle read strobe. Operation 1011 writes rA to the peripheral at address rB with a one-cycle write strobe.
- R8: Operation 1100 loads rA from memory at address rB. Operation 1101 stores rA to memory at address rB.
- R9: Operation 1110 compares rA and rB as unsigned values. When rA < rB, the next instruction is skipped; when they are equal or rA is larger, it is not.
- R10: Operation 1111 exchanges rA and rB within one instruction.
- R11: Any operation whose destination is register 3 redirects execution to the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_addr | output | 8 | Memory address: the program counter in fetch, rB for a load or store |
| mem_rdata | input | 8 | Memory read data, valid in the same cycle as mem_addr |
| mem_wdata | output | 8 | Memory write data (rA) |
| mem_we | output | 1 | Memory write enable, high only while executing a store |
| io_addr | output | 8 | Peripheral address (rB) |
| io_rdata | input | 8 | Peripheral read data, sampled in the strobe cycle |
| io_wdata | output | 8 | Peripheral write data (rA) |
| io_rd | output | 1 | Single-cycle peripheral read strobe |
| io_wr | output | 1 | Single-cycle peripheral write strobe |

## Verification
The embedded assertions check properties that hold on every cycle:
- each fetch addresses the program counter with every write strobe low;
- the counter steps by exactly one after each fetch;
- the strobes never stay high for two cycles;
- a low-nibble load clears the high nibble;
- an exchange swaps both registers;
- a taken skip adds one more step.

The bench's programs are the only way to show the end-to-end results:
- arithmetic results, including the wrap past 255;
- unsigned ordering at the equal and extreme operands;
- data passing through memory and peripherals;
- a jump that really bypasses instructions.

// File: rtl/mrc_pkg.sv
package mrc_pkg;
  parameter int unsigned DATA_W  = 8;
  parameter int unsigned REG_N   = 4;
  parameter int unsigned REGIX_W = $clog2(REG_N);
  parameter int unsigned IMM_W   = 4;
  parameter int unsigned PC_IDX  = REG_N - 1;

  typedef enum logic [3:0] {
    K_LIL, K_LIH, K_ADD, K_NAND, K_IORD, K_IOWR,
    K_LOAD, K_STORE, K_SKIP, K_SWAP
  } op_kind_e;

  typedef struct packed {
    op_kind_e             kind;
    logic [REGIX_W-1:0]   ra;
    logic [REGIX_W-1:0]   rb;
    logic [IMM_W-1:0]     imm;
  } dec_t;

  typedef enum logic {ST_FETCH, ST_EXEC} core_st_e;
endpackage

// File: rtl/mrc_decode.sv
module mrc_decode
  import mrc_pkg::*;
(
  input  logic [DATA_W-1:0] instr,
  output dec_t              dec
);
  always_comb begin
    dec.ra  = instr[3:2];
    dec.rb  = instr[1:0];
    // constant is split: upper half from [5:4], lower half from [1:0]
    dec.imm = {instr[5:4], instr[1:0]};
    unique casez (instr[7:4])
      4'b00??: dec.kind = K_LIL;
      4'b01??: dec.kind = K_LIH;
      4'b1000: dec.kind = K_ADD;
      4'b1001: dec.kind = K_NAND;
      4'b1010: dec.kind = K_IORD;
      4'b1011: dec.kind = K_IOWR;
      4'b1100: dec.kind = K_LOAD;
      4'b1101: dec.kind = K_STORE;
      4'b1110: dec.kind = K_SKIP;
      default: dec.kind = K_SWAP;
    endcase
  end
endmodule

// File: rtl/mrc_regfile.sv
module mrc_regfile
  import mrc_pkg::*;
#(
  parameter int unsigned DW  = DATA_W,
  parameter int unsigned NR  = REG_N,
  parameter int unsigned IW  = REGIX_W,
  parameter int unsigned PCI = PC_IDX
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pc_inc,
  input  logic                  wa_en,
  input  logic [IW-1:0]         wa_idx,
  input  logic [DW-1:0]         wa_data,
  input  logic                  wb_en,
  input  logic [IW-1:0]         wb_idx,
  input  logic [DW-1:0]         wb_data,
  output logic [NR-1:0][DW-1:0] regs
);
  for (genvar g = 0; g < NR; g++) begin : g_reg
    logic          hit_a, hit_b, step, en;
    logic [DW-1:0] nxt, q;

    // port A wins over port B, both win over the counter step
    always_comb begin
      hit_a = wa_en && (wa_idx == IW'(g));
      hit_b = wb_en && (wb_idx == IW'(g));
      step  = pc_inc && (g == PCI);
      en    = hit_a || hit_b || step;
      nxt   = q;
      if (step)  nxt = q + 1'b1;
      if (hit_b) nxt = wb_data;
      if (hit_a) nxt = wa_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= nxt;
    end

    assign regs[g] = q;
  end

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_inc && !wa_en && !wb_en) |=> regs[PCI] == DW'($past(regs[PCI]) + 1'b1)); // R2
endmodule

// File: rtl/mrc_exec.sv
module mrc_exec
  import mrc_pkg::*;
#(
  parameter int unsigned DW  = DATA_W,
  parameter int unsigned IW  = REGIX_W,
  parameter int unsigned KW  = IMM_W,
  parameter int unsigned PCI = PC_IDX
) (
  input  logic          exec_en,
  input  dec_t          dec,
  input  logic [DW-1:0] ra_val,
  input  logic [DW-1:0] rb_val,
  input  logic [DW-1:0] pc_val,
  input  logic [DW-1:0] mem_rdata,
  input  logic [DW-1:0] io_rdata,
  output logic          wa_en,
  output logic [IW-1:0] wa_idx,
  output logic [DW-1:0] wa_data,
  output logic          wb_en,
  output logic [IW-1:0] wb_idx,
  output logic [DW-1:0] wb_data,
  output logic          data_cyc,
  output logic          mem_we,
  output logic          io_rd,
  output logic          io_wr
);
  localparam int unsigned HI_W = DW - KW;

  always_comb begin
    wa_en    = 1'b0;
    wa_idx   = dec.ra;
    wa_data  = '0;
    wb_en    = 1'b0;
    wb_idx   = dec.rb;
    wb_data  = ra_val;
    data_cyc = 1'b0;
    mem_we   = 1'b0;
    io_rd    = 1'b0;
    io_wr    = 1'b0;
    if (exec_en) begin
      unique case (dec.kind)
        K_LIL:   begin wa_en = 1'b1; wa_data = {{HI_W{1'b0}}, dec.imm}; end
        K_LIH:   begin wa_en = 1'b1; wa_data = {dec.imm, ra_val[HI_W-1:0]}; end
        K_ADD:   begin wa_en = 1'b1; wa_data = ra_val + rb_val; end
        K_NAND:  begin wa_en = 1'b1; wa_data = ~(ra_val & rb_val); end
        K_IORD:  begin wa_en = 1'b1; wa_data = io_rdata; io_rd = 1'b1; end
        K_IOWR:  io_wr = 1'b1;
        K_LOAD:  begin wa_en = 1'b1; wa_data = mem_rdata; data_cyc = 1'b1; end
        K_STORE: begin mem_we = 1'b1; data_cyc = 1'b1; end
        K_SKIP:  begin
          if (ra_val < rb_val) begin
            wa_en   = 1'b1;
            wa_idx  = IW'(PCI);
            wa_data = pc_val + 1'b1;
          end
        end
        default: begin
          wa_en   = 1'b1;
          wa_data = rb_val;
          wb_en   = 1'b1;
          wb_data = ra_val;
        end
      endcase
    end
  end
endmodule

// File: rtl/mini_risc_core.sv
module mini_risc_core
  import mrc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  output logic [DATA_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic [DATA_W-1:0] io_addr,
  input  logic [DATA_W-1:0] io_rdata,
  output logic [DATA_W-1:0] io_wdata,
  output logic              io_rd,
  output logic              io_wr
);
  localparam int unsigned DW = DATA_W;
  localparam int unsigned IW = REGIX_W;

  // reset synchronizer: asserts at once, releases on the clock
  logic rs_q1, rs_q2, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end
  assign rst_core_n = rs_q2;

  core_st_e                st_q, st_d;
  logic [DW-1:0]           ir_q, ir_d;
  logic                    ir_en;
  dec_t                    dec;
  logic [REG_N-1:0][DW-1:0] regs;
  logic [DW-1:0]           ra_val, rb_val, pc;
  logic                    wa_en, wb_en, data_cyc, exec_en, pc_inc;
  logic [IW-1:0]           wa_idx, wb_idx;
  logic [DW-1:0]           wa_data, wb_data;

  always_comb begin
    st_d  = (st_q == ST_FETCH) ? ST_EXEC : ST_FETCH;
    ir_en = (st_q == ST_FETCH);
    ir_d  = mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      st_q <= ST_FETCH;
      ir_q <= '0;
    end else begin
      st_q <= st_d;
      if (ir_en) ir_q <= ir_d;
    end
  end

  mrc_decode u_dec (.instr(ir_q), .dec(dec));

  assign ra_val  = regs[dec.ra];
  assign rb_val  = regs[dec.rb];
  assign pc      = regs[PC_IDX];
  assign exec_en = (st_q == ST_EXEC);
  assign pc_inc  = (st_q == ST_FETCH);

  mrc_regfile #(.DW(DW), .NR(REG_N), .IW(IW), .PCI(PC_IDX)) u_rf (
    .clk(clk), .rst_n(rst_core_n), .pc_inc(pc_inc),
    .wa_en(wa_en), .wa_idx(wa_idx), .wa_data(wa_data),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
    .regs(regs)
  );

  mrc_exec #(.DW(DW), .IW(IW), .KW(IMM_W), .PCI(PC_IDX)) u_ex (
    .exec_en(exec_en), .dec(dec), .ra_val(ra_val), .rb_val(rb_val),
    .pc_val(pc), .mem_rdata(mem_rdata), .io_rdata(io_rdata),
    .wa_en(wa_en), .wa_idx(wa_idx), .wa_data(wa_data),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
    .data_cyc(data_cyc), .mem_we(mem_we), .io_rd(io_rd), .io_wr(io_wr)
  );

  assign mem_addr  = (exec_en && data_cyc) ? rb_val : pc;
  assign mem_wdata = ra_val;
  assign io_addr   = rb_val;
  assign io_wdata  = ra_val;

  AST_FETCH_BUS: assert property (@(posedge clk) disable iff (!rst_core_n)
    (st_q == ST_FETCH) |-> (mem_addr == pc && !mem_we && !io_rd && !io_wr)); // R2
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_core_n)
    io_rd |=> !io_rd); // R7
  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_core_n)
    io_wr |=> !io_wr); // R7
  AST_LIL_CLEARS_HIGH: assert property (@(posedge clk) disable iff (!rst_core_n)
    (exec_en && dec.kind == K_LIL) |=> regs[dec.ra][DW-1:IMM_W] == '0); // R3
  AST_SWAP_XCHG: assert property (@(posedge clk) disable iff (!rst_core_n)
    (exec_en && dec.kind == K_SWAP) |=>
      (regs[dec.ra] == $past(rb_val) && regs[dec.rb] == $past(ra_val))); // R10
  AST_SKIP_STEP: assert property (@(posedge clk) disable iff (!rst_core_n)
    (exec_en && dec.kind == K_SKIP && ra_val < rb_val) |=>
      pc == DW'($past(pc) + 1'b1)); // R9
endmodule

// File: tb/tb_mini_risc_core.sv
module tb_mini_risc_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] mem_addr, mem_rdata, mem_wdata, io_addr, io_rdata, io_wdata;
  logic       mem_we, io_rd, io_wr;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  mini_risc_core dut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .io_addr(io_addr),
    .io_rdata(io_rdata), .io_wdata(io_wdata), .io_rd(io_rd), .io_wr(io_wr)
  );

  // memory model with a loader port driven by the bench
  logic [7:0] mem [256];
  logic [7:0] img [256];
  logic       ld_en = 1'b0;
  logic [7:0] ld_a = '0, ld_d = '0;
  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) begin
    if (ld_en) mem[ld_a] <= ld_d;
    else if (mem_we) mem[mem_addr] <= mem_wdata;
  end

  // peripheral model: read returns address ^ 5A
  assign io_rdata = io_addr ^ 8'h5A;
  logic [7:0] cap_a [8];
  logic [7:0] cap_d [8];
  int         cap_n = 0;
  int         rd_n = 0;
  logic [7:0] rd_a = '0;
  logic       cap_clr = 1'b0;
  always @(negedge clk) begin
    if (cap_clr) begin
      cap_n <= 0;
      rd_n  <= 0;
    end else begin
      if (io_wr && cap_n < 8) begin
        cap_a[cap_n] <= io_addr;
        cap_d[cap_n] <= io_wdata;
        cap_n <= cap_n + 1;
      end
      if (io_rd) begin
        rd_n <= rd_n + 1;
        rd_a <= io_addr;
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] f_imm(bit hi, logic [3:0] k, logic [1:0] ra);
    return {1'b0, hi, k[3:2], ra, k[1:0]};
  endfunction
  function automatic logic [7:0] f_rr(logic [3:0] op, logic [1:0] ra, logic [1:0] rb);
    return {op, ra, rb};
  endfunction

  task automatic clear_img();
    for (int i = 0; i < 256; i++) img[i] = 8'h00;
  endtask

  bit first_run = 1'b1;

  task automatic run_prog(int n_io);
    rst_n = 1'b0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_a = 8'(i); ld_d = img[i];
    end
    @(negedge clk);
    ld_en = 1'b0; cap_clr = 1'b1;
    if (first_run) begin
      check("R1 mem_addr in reset", int'(mem_addr), 0);
      check("R1 mem_we in reset", int'(mem_we), 0);
      check("R1 io_rd in reset", int'(io_rd), 0);
      check("R1 io_wr in reset", int'(io_wr), 0);
      first_run = 1'b0;
    end
    @(negedge clk);
    cap_clr = 1'b0;
    rst_n = 1'b1;
    for (int c = 0; c < 300 && cap_n < n_io; c++) @(negedge clk);
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
  endtask

  localparam logic [3:0] OP_ADD = 4'b1000, OP_NAND = 4'b1001, OP_IOR = 4'b1010,
                         OP_IOW = 4'b1011, OP_LOA = 4'b1100, OP_STO = 4'b1101,
                         OP_SKL = 4'b1110, OP_SWP = 4'b1111;

  // two-operand program, results sent to peripheral address 1 (0 if skipped)
  task automatic run_alu(logic [3:0] op, logic [7:0] a, logic [7:0] b);
    logic [7:0] e0, e1, ea;
    string tag;
    clear_img();
    img[0] = f_imm(0, a[3:0], 2'd0);
    img[1] = f_imm(1, a[7:4], 2'd0);
    img[2] = f_imm(0, b[3:0], 2'd1);
    img[3] = f_imm(1, b[7:4], 2'd1);
    img[4] = f_rr(op, 2'd0, 2'd1);
    img[5] = f_imm(0, 4'd1, 2'd2);
    img[6] = f_rr(OP_IOW, 2'd0, 2'd2);
    img[7] = f_rr(OP_IOW, 2'd1, 2'd2);
    e0 = a; e1 = b; ea = 8'd1;
    case (op)
      OP_ADD:  begin e0 = a + b;    tag = "R5 add"; end
      OP_NAND: begin e0 = ~(a & b); tag = "R6 nand"; end
      OP_SKL:  begin if (a < b) ea = 8'd0; tag = "R9 skip"; end
      default: begin e0 = b; e1 = a; tag = "R10 swap"; end
    endcase
    run_prog(2);
    check({tag, " count"}, cap_n, 2);
    check({tag, " addr0"}, int'(cap_a[0]), int'(ea));
    check({tag, " data0"}, int'(cap_d[0]), int'(e0));
    check({tag, " addr1"}, int'(cap_a[1]), int'(ea));
    check({tag, " data1"}, int'(cap_d[1]), int'(e1));
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd20240611);

    // R3 / R4 nibble loads
    clear_img();
    img[0] = f_imm(0, 4'hF, 2'd0);
    img[1] = f_imm(1, 4'hF, 2'd0);
    img[2] = f_imm(0, 4'h3, 2'd0);
    img[3] = f_rr(OP_IOW, 2'd0, 2'd2);
    img[4] = f_imm(1, 4'hA, 2'd0);
    img[5] = f_rr(OP_IOW, 2'd0, 2'd2);
    run_prog(2);
    check("R3 low load clears high", int'(cap_d[0]), 8'h03);
    check("R4 high load keeps low", int'(cap_d[1]), 8'hA3);

    // directed arithmetic, compare and swap corners
    run_alu(OP_ADD, 8'hF0, 8'h20);
    run_alu(OP_ADD, 8'hFF, 8'hFF);
    run_alu(OP_NAND, 8'hCC, 8'hAA);
    run_alu(OP_SKL, 8'h03, 8'h04);
    run_alu(OP_SKL, 8'h04, 8'h04);
    run_alu(OP_SKL, 8'hFF, 8'h01);
    run_alu(OP_SKL, 8'h01, 8'hFF);
    run_alu(OP_SWP, 8'h12, 8'hE7);

    // R7 peripheral read then write
    clear_img();
    img[0] = f_imm(0, 4'h7, 2'd1);
    img[1] = f_imm(1, 4'h3, 2'd1);
    img[2] = f_rr(OP_IOR, 2'd0, 2'd1);
    img[3] = f_rr(OP_IOW, 2'd0, 2'd2);
    run_prog(1);
    check("R7 read strobes", rd_n, 1);
    check("R7 read address", int'(rd_a), 8'h37);
    check("R7 read data", int'(cap_d[0]), 8'h6D);
    check("R7 write address", int'(cap_a[0]), 0);

    // R8 store then load back, plus load of preset data
    clear_img();
    img[0]  = f_imm(0, 4'hC, 2'd0);
    img[1]  = f_imm(1, 4'h9, 2'd0);
    img[2]  = f_imm(0, 4'h0, 2'd1);
    img[3]  = f_imm(1, 4'h8, 2'd1);
    img[4]  = f_rr(OP_STO, 2'd0, 2'd1);
    img[5]  = f_imm(0, 4'h0, 2'd0);
    img[6]  = f_rr(OP_LOA, 2'd0, 2'd1);
    img[7]  = f_rr(OP_IOW, 2'd0, 2'd2);
    img[8]  = f_imm(1, 4'h4, 2'd1);
    img[9]  = f_rr(OP_LOA, 2'd0, 2'd1);
    img[10] = f_rr(OP_IOW, 2'd0, 2'd2);
    img[8'h40] = 8'h5E;
    run_prog(2);
    check("R8 stored byte in memory", int'(mem[8'h80]), 8'h9C);
    check("R8 load after store", int'(cap_d[0]), 8'h9C);
    check("R8 load preset", int'(cap_d[1]), 8'h5E);

    // R2 / R11 program counter read and jump
    clear_img();
    img[0] = f_rr(OP_IOW, 2'd3, 2'd2);
    img[1] = f_imm(0, 4'h5, 2'd3);
    img[2] = f_rr(OP_IOW, 2'd3, 2'd2);
    img[5] = f_imm(0, 4'h9, 2'd0);
    img[6] = f_rr(OP_IOW, 2'd0, 2'd2);
    run_prog(2);
    check("R2 pc reads next address", int'(cap_d[0]), 1);
    check("R11 jump bypasses code", int'(cap_d[1]), 9);
    check("R11 write count", cap_n, 2);

    // constrained random operand mix
    for (int it = 0; it < 40; it++) begin
      logic [3:0] op;
      case ($urandom % 4)
        0: op = OP_ADD;
        1: op = OP_NAND;
        2: op = OP_SKL;
        default: op = OP_SWP;
      endcase
      run_alu(op, 8'($urandom), 8'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule